// File: doc/BRIEF.md
# Error Flag Override Port

This block sits beside the error-flag path of a video error-detection packet generator. It gives an external controller a narrow, synchronous, five-pin bidirectional port to the fifteen outgoing error flags. The flags are split into three groups of five: ancillary, full-field and active-picture. The port also reaches the two outgoing validity bits, for active picture and full field. A two-bit group select picks what the pins carry. A direction pin decides whether the controller drives the pins or the block drives them.

In write mode, each clock edge captures the pins into the selected group and marks those flags as pending. A pending flag replaces whatever the host registers or the normal flag logic would have produced, and it lasts only until the next packet leaves. The packet-sent strobe clears every pending mark. After that, each flag falls back to its host override if one is enabled, and otherwise to the current computed value. In read mode, the block drives the selected group of final flags onto the pins.

Top module: `flag_port_ovr`

## Requirements
- R1: After reset nothing is pending: with no host override enabled, `flags_o` equals `cur_flags`, `apv_o` equals `cur_apv` and `ffv_o` equals `cur_ffv`.
- R2: When `dir_rd` is 0 at a clock edge and `grp_sel` is 0, 1 or 2, `pin_in` replaces `flags_o[4:0]`, `flags_o[9:5]` or `flags_o[14:10]` respectively. The new values show from that edge on.
- R3: When `dir_rd` is 0 and `grp_sel` is 3, `pin_in[0]` becomes the pending `apv_o` and `pin_in[1]` becomes the pending `ffv_o`. `pin_in[4:2]` is ignored.
- R4: A pending port value wins over an enabled host override on the same flag.
- R5: `pkt_sent` high at a clock edge clears all pending flags and validity bits. Each flag then shows `host_val` where `host_en` is set, and `cur_flags` elsewhere.
- R6: With nothing pending, each flag shows `host_val` where `host_en` is 1 and `cur_flags` where it is 0.
- R7: When `dir_rd` is 1, `pin_oe` is 1. `pin_out` carries final flags [4:0], [9:5] or [14:10] for select 0, 1 or 2. For select 3 it carries {000, `ffv_o`, `apv_o`}.
- R8: When `dir_rd` is 0, `pin_oe` is 0.
- R9: While `dir_rd` is 1, `pin_in` has no effect on any output.
- R10: A write in the same cycle as `pkt_sent` survives the clear and holds until the following `pkt_sent`.
- R11: Groups written separately accumulate. Flags in groups not written keep their host or computed value, and pending values do not follow later changes on `cur_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rd | input | 1 | 1 = block drives pins, 0 = pins are captured |
| grp_sel | input | 2 | Group select: 0 ancillary, 1 full-field, 2 active-picture, 3 validity |
| pin_in | input | 5 | Value on the port pins |
| pin_out | output | 5 | Value the block drives onto the pins |
| pin_oe | output | 1 | Output enable for the pins |
| cur_flags | input | 15 | Flags from the normal error logic |
| cur_apv | input | 1 | Computed active-picture validity bit |
| cur_ffv | input | 1 | Computed full-field validity bit |
| host_val | input | 15 | Host override values |
| host_en | input | 15 | Host override enables, one per flag |
| pkt_sent | input | 1 | Strobe: an outgoing packet has taken the flags |
| flags_o | output | 15 | Final outgoing error flags |
| apv_o | output | 1 | Final active-picture validity bit |
| ffv_o | output | 1 | Final full-field validity bit |

## Verification
A write or a `pkt_sent` acts through a single register stage. Its effect on `flags_o`, `apv_o`, `ffv_o` and `pin_out` is therefore due right after the edge that samples it. `pin_oe`, and any change on `cur_flags`, `host_en` or `host_val`, reach the outputs within the same cycle with no edge at all. The driver sets inputs on the falling edge, updates its model at the rising edge, and queues the expected outputs for that cycle. The monitor compares one nanosecond after the same rising edge, while the inputs are still held. Every check thus lands in the first cycle in which the result is due.

// File: rtl/flag_port_ovr.sv
module flag_port_ovr #(
  parameter int GRP_W = 5,
  parameter int NGRP  = 3,
  parameter int SEL_W = $clog2(NGRP + 1),
  parameter int NFLAG = GRP_W * NGRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic [SEL_W-1:0] grp_sel,
  input  logic [GRP_W-1:0] pin_in,
  output logic [GRP_W-1:0] pin_out,
  output logic             pin_oe,
  input  logic [NFLAG-1:0] cur_flags,
  input  logic             cur_apv,
  input  logic             cur_ffv,
  input  logic [NFLAG-1:0] host_val,
  input  logic [NFLAG-1:0] host_en,
  input  logic             pkt_sent,
  output logic [NFLAG-1:0] flags_o,
  output logic             apv_o,
  output logic             ffv_o
);

  localparam logic [SEL_W-1:0] VSEL = SEL_W'(NGRP);

  logic [NFLAG-1:0] pmask, pval;
  logic             pa_m, pa_v, pf_m, pf_v;
  logic             wr;

  assign wr = !dir_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask <= '0;
      pval  <= '0;
      pa_m  <= 1'b0;
      pa_v  <= 1'b0;
      pf_m  <= 1'b0;
      pf_v  <= 1'b0;
    end else begin
      if (pkt_sent) begin
        pmask <= '0;
        pa_m  <= 1'b0;
        pf_m  <= 1'b0;
      end
      for (int g = 0; g < NGRP; g++) begin
        if (wr && grp_sel == SEL_W'(g)) begin
          pmask[g*GRP_W +: GRP_W] <= '1;
          pval[g*GRP_W +: GRP_W]  <= pin_in;
        end
      end
      if (wr && grp_sel == VSEL) begin
        pa_m <= 1'b1;
        pa_v <= pin_in[0];
        pf_m <= 1'b1;
        pf_v <= pin_in[1];
      end
    end
  end

  assign flags_o = (pmask & pval) |
                   (~pmask & ((host_en & host_val) | (~host_en & cur_flags)));
  assign apv_o   = pa_m ? pa_v : cur_apv;
  assign ffv_o   = pf_m ? pf_v : cur_ffv;
  assign pin_oe  = dir_rd;

  always_comb begin
    pin_out = '0;
    for (int g = 0; g < NGRP; g++)
      if (grp_sel == SEL_W'(g)) pin_out = flags_o[g*GRP_W +: GRP_W];
    if (grp_sel == VSEL) pin_out[1:0] = {ffv_o, apv_o};
  end

endmodule

// File: rtl/flag_port_ovr_chk.sv
module flag_port_ovr_chk #(
  parameter int GRP_W = 5,
  parameter int NGRP  = 3,
  parameter int SEL_W = 2,
  parameter int NFLAG = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_rd,
  input logic [SEL_W-1:0] grp_sel,
  input logic [GRP_W-1:0] pin_in,
  input logic [GRP_W-1:0] pin_out,
  input logic             pin_oe,
  input logic             pkt_sent,
  input logic [NFLAG-1:0] flags_o,
  input logic             apv_o,
  input logic             ffv_o,
  input logic [NFLAG-1:0] pmask,
  input logic [NFLAG-1:0] pval,
  input logic             pa_m,
  input logic             pf_m
);

  // R2
  grp0_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && grp_sel == '0) |=> (flags_o[GRP_W-1:0] == $past(pin_in)));

  // R3
  valid_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && grp_sel == SEL_W'(NGRP)) |=>
      (apv_o == $past(pin_in[0]) && ffv_o == $past(pin_in[1])));

  // R5
  pkt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && dir_rd) |=> (pmask == '0 && !pa_m && !pf_m));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && !pkt_sent) |=> ($stable(pmask) && $stable(pval)));

  // R8
  write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_rd |-> !pin_oe);

  // R7
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && grp_sel == '0) |-> (pin_oe && pin_out == flags_o[GRP_W-1:0]));

endmodule

bind flag_port_ovr flag_port_ovr_chk #(
  .GRP_W(GRP_W), .NGRP(NGRP), .SEL_W(SEL_W), .NFLAG(NFLAG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .grp_sel(grp_sel),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pkt_sent(pkt_sent),
  .flags_o(flags_o), .apv_o(apv_o), .ffv_o(ffv_o),
  .pmask(pmask), .pval(pval), .pa_m(pa_m), .pf_m(pf_m)
);

// File: tb/flag_port_ovr_test.sv
`timescale 1ns/1ps
module flag_port_ovr_test;

  typedef struct packed {
    logic [14:0] flags;
    logic        apv;
    logic        ffv;
    logic [4:0]  pout;
    logic        oe;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rd = 1'b1;
  logic [1:0]  grp_sel = '0;
  logic [4:0]  pin_in = '0;
  logic [4:0]  pin_out;
  logic        pin_oe;
  logic [14:0] cur_flags = '0;
  logic        cur_apv = 1'b0, cur_ffv = 1'b0;
  logic [14:0] host_val = '0, host_en = '0;
  logic        pkt_sent = 1'b0;
  logic [14:0] flags_o;
  logic        apv_o, ffv_o;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t  expq[$];
  string tagq[$];

  logic [14:0] m_pm = '0, m_pv = '0;
  logic        m_am = 0, m_av = 0, m_fm = 0, m_fv = 0;

  always #2.5 clk = ~clk;

  flag_port_ovr uut (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .grp_sel(grp_sel),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .cur_flags(cur_flags), .cur_apv(cur_apv), .cur_ffv(cur_ffv),
    .host_val(host_val), .host_en(host_en), .pkt_sent(pkt_sent),
    .flags_o(flags_o), .apv_o(apv_o), .ffv_o(ffv_o)
  );

  task automatic drive(input logic rd, input logic [1:0] sel, input logic [4:0] pin,
                       input logic [14:0] cur, input logic ca, input logic cf,
                       input logic [14:0] hen, input logic [14:0] hval,
                       input logic pkt, input string tag);
    exp_t e;
    @(negedge clk);
    dir_rd = rd; grp_sel = sel; pin_in = pin; cur_flags = cur;
    cur_apv = ca; cur_ffv = cf; host_en = hen; host_val = hval; pkt_sent = pkt;
    @(posedge clk);
    if (pkt) begin m_pm = '0; m_am = 0; m_fm = 0; end
    if (!rd) begin
      case (sel)
        2'd0: begin m_pm[4:0]   = '1; m_pv[4:0]   = pin; end
        2'd1: begin m_pm[9:5]   = '1; m_pv[9:5]   = pin; end
        2'd2: begin m_pm[14:10] = '1; m_pv[14:10] = pin; end
        default: begin m_am = 1; m_av = pin[0]; m_fm = 1; m_fv = pin[1]; end
      endcase
    end
    for (int i = 0; i < 15; i++)
      e.flags[i] = m_pm[i] ? m_pv[i] : (hen[i] ? hval[i] : cur[i]);
    e.apv = m_am ? m_av : ca;
    e.ffv = m_fm ? m_fv : cf;
    e.oe  = rd;
    case (sel)
      2'd0: e.pout = e.flags[4:0];
      2'd1: e.pout = e.flags[9:5];
      2'd2: e.pout = e.flags[14:10];
      default: e.pout = {3'b000, e.ffv, e.apv};
    endcase
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        t = tagq.pop_front();
        checks++;
        if (flags_o !== e.flags || apv_o !== e.apv || ffv_o !== e.ffv ||
            pin_oe !== e.oe || (e.oe && pin_out !== e.pout)) begin
          fails++;
          $display("FAIL %s: got flags=%h apv=%b ffv=%b oe=%b out=%h exp flags=%h apv=%b ffv=%b oe=%b out=%h",
                   t, flags_o, apv_o, ffv_o, pin_oe, pin_out,
                   e.flags, e.apv, e.ffv, e.oe, e.pout);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    drive(1, 0, 5'h00, 15'h2A5C, 1, 0, 15'h0000, 15'h0000, 0, "R1");
    drive(1, 3, 5'h00, 15'h2A5C, 1, 0, 15'h0000, 15'h0000, 0, "R1");
    // R6 host overrides
    drive(1, 1, 5'h00, 15'h2A5C, 1, 0, 15'h03FF, 15'h0155, 0, "R6");
    // R2 / R8 write ancillary group
    drive(0, 0, 5'h15, 15'h2A5C, 1, 0, 15'h03FF, 15'h0155, 0, "R2");
    // R4 write full-field group over host override
    drive(0, 1, 5'h0E, 15'h2A5C, 1, 0, 15'h03FF, 15'h0155, 0, "R4");
    // R11 write active-picture group, earlier groups held, cur changes
    drive(0, 2, 5'h13, 15'h55A3, 1, 0, 15'h03FF, 15'h0155, 0, "R11");
    drive(1, 0, 5'h1F, 15'h7FFF, 1, 0, 15'h0000, 15'h0000, 0, "R11");
    // R3 validity overrides, upper bits ignored
    drive(0, 3, 5'h1E, 15'h7FFF, 1, 0, 15'h0000, 15'h0000, 0, "R3");
    // R7 read each group, R9 pin_in toggling has no effect
    drive(1, 0, 5'h0A, 15'h1234, 1, 0, 15'h0F0F, 15'h7000, 0, "R7");
    drive(1, 1, 5'h15, 15'h1234, 1, 0, 15'h0F0F, 15'h7000, 0, "R7");
    drive(1, 2, 5'h1F, 15'h1234, 1, 0, 15'h0F0F, 15'h7000, 0, "R7");
    drive(1, 3, 5'h00, 15'h1234, 0, 1, 15'h0F0F, 15'h7000, 0, "R9");
    // R5 packet clears everything
    drive(1, 3, 5'h1F, 15'h1234, 0, 1, 15'h0F0F, 15'h7000, 1, "R5");
    drive(1, 1, 5'h1F, 15'h4321, 1, 1, 15'h00F0, 15'h00A0, 0, "R5");
    // R10 write together with packet survives
    drive(0, 2, 5'h0C, 15'h0000, 0, 0, 15'h7C00, 15'h7C00, 1, "R10");
    drive(1, 2, 5'h00, 15'h0000, 0, 0, 15'h7C00, 15'h7C00, 0, "R10");
    drive(1, 2, 5'h00, 15'h0000, 0, 0, 15'h7C00, 15'h7C00, 1, "R10");
    // R8 write with validity select, pins released
    drive(0, 3, 5'h01, 15'h0000, 0, 1, 15'h0000, 15'h0000, 0, "R8");
    drive(1, 3, 5'h00, 15'h0000, 0, 1, 15'h0000, 15'h0000, 1, "R5");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule